// File: doc/BRIEF.md
# Receive Byte Queue with Selectable Fill Threshold

This block buffers incoming serial bytes between a deserializer and a register bus. The deserializer offers one byte per cycle on a push port. The bus drains bytes from a pop port, which shows the oldest stored byte combinationally. The queue holds sixteen bytes. A byte that arrives while the queue is full is discarded. Bytes are accepted only while reception is enabled.

A control write port sets the fill threshold from a 2-bit field and can empty the queue in one cycle. A threshold flag rises when an accepted byte brings the occupancy to or above the threshold. It falls when a pop takes the occupancy below the threshold. Single-cycle set and clear indications tell the surrounding status logic when these events happen. An interrupt request follows the flag-set event, gated by an interrupt enable input.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset, count is 0, full_flag is 0, rx_irq is 0, pop_data is 0x00 and the threshold is 1.
- R2: Bytes leave in the order they were accepted. pop_data shows the oldest byte combinationally while count is nonzero. The storage indices wrap, so ordering holds across more than sixteen bytes in total.
- R3: A push while count is 16 is dropped. The count stays 16, the stored bytes are unchanged and flag_set stays low. count never exceeds 16.
- R4: A push while rx_en is 0 is ignored and leaves count unchanged.
- R5: A pop while count is 0 changes no state, and pop_data reads 0x00.
- R6: A write on the control port loads the threshold from ctl_wdata[7:6]: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 14. The new threshold applies from the following cycle. An accepted push whose resulting count is at or above the threshold sets full_flag.
- R7: A pop whose resulting count is below the threshold clears full_flag. A pop that leaves count at or above the threshold leaves full_flag set.
- R8: A control write with ctl_wdata[1] = 1 empties the queue and clears full_flag and rx_irq. It takes priority over a push or pop in the same cycle.
- R9: An accepted push and a pop in the same cycle leave count unchanged and keep the byte order.
- R10: rx_irq rises on a flag-set event while rx_ie is 1. It is 0 in the cycle after rx_ie is 0, and it falls on a flag-clear event or a flush. rx_irq is never 1 while full_flag is 0.
- R11: flag_set is high during the cycle of an accepted push whose resulting count is at or above the threshold. flag_clr is high during the cycle of a pop whose resulting count is below the threshold, or of a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Reception enable; pushes are ignored when 0 |
| rx_ie | input | 1 | Receive interrupt enable |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control data: [7:6] threshold select, [1] flush |
| push_valid | input | 1 | Byte offered by the deserializer |
| push_data | input | 8 | Offered byte |
| pop | input | 1 | Bus read of the oldest byte |
| pop_data | output | 8 | Oldest byte, 0x00 when empty |
| count | output | 5 | Occupancy, 0 to 16 |
| full_flag | output | 1 | Threshold flag |
| flag_set | output | 1 | Flag-set event in this cycle |
| flag_clr | output | 1 | Flag-clear event in this cycle |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The hardest situations to reach are the edges of the occupancy range under each threshold setting. These are a pop that lands exactly one below the threshold, one that stays exactly at it, and a push that hits a full queue. To reach them, the stimulus first programs each of the four levels, then fills the queue to one below the level, one at it and one above it before popping. Ordering across index wrap is reached by a long alternating push/pop run after an initial offset of five entries. The flush-versus-push collision is driven in a single cycle with the interrupt already raised.

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          rx_ie,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  input  logic          push_valid,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count,
  output logic          full_flag,
  output logic          flag_set,
  output logic          flag_clr,
  output logic          rx_irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [1:0]    trig_sel;
  logic [CW-1:0] trig_lvl, cnt_n;
  logic          flush, push_ok, pop_ok, irq_n;

  assign flush   = ctl_we & ctl_wdata[1];
  assign push_ok = push_valid & rx_en & ~flush & (count != FULL);
  assign pop_ok  = pop & ~flush & (count != '0);

  always_comb begin
    case (trig_sel)
      2'd0:    trig_lvl = CW'(LVL0);
      2'd1:    trig_lvl = CW'(LVL1);
      2'd2:    trig_lvl = CW'(LVL2);
      default: trig_lvl = CW'(LVL3);
    endcase
  end

  always_comb begin
    case ({push_ok, pop_ok})
      2'b10:   cnt_n = count + 1'b1;
      2'b01:   cnt_n = count - 1'b1;
      default: cnt_n = count;
    endcase
  end

  assign flag_set = push_ok & (cnt_n >= trig_lvl);
  assign flag_clr = flush | (pop_ok & (cnt_n < trig_lvl));
  assign pop_data = (count != '0) ? mem[rd_ptr] : '0;

  always_comb begin
    irq_n = rx_irq;
    if (flush || !rx_ie) irq_n = 1'b0;
    else if (flag_set)   irq_n = 1'b1;
    else if (flag_clr)   irq_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      trig_sel  <= 2'd0;
      full_flag <= 1'b0;
      rx_irq    <= 1'b0;
    end else begin
      if (ctl_we) trig_sel <= ctl_wdata[7:6];
      if (flush) begin
        wr_ptr    <= '0;
        rd_ptr    <= '0;
        count     <= '0;
        full_flag <= 1'b0;
      end else begin
        if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        count <= cnt_n;
        if (flag_set)      full_flag <= 1'b1;
        else if (flag_clr) full_flag <= 1'b0;
      end
      rx_irq <= irq_n;
    end
  end
endmodule

module rx_trig_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          rx_ie,
  input logic          ctl_we,
  input logic          flush_bit,
  input logic          push_valid,
  input logic          pop,
  input logic [CW-1:0] count,
  input logic          full_flag,
  input logic          rx_irq
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  logic fl;
  assign fl = ctl_we & flush_bit;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL);
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL) && push_valid && !pop && !fl |=> $stable(count));
  p_rx_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en && !pop && !fl |=> $stable(count));
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) && pop && !(push_valid && rx_en) && !fl |=> (count == '0) && !full_flag);
  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fl |=> (count == '0) && !full_flag && !rx_irq);
  p_both_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && rx_en && pop && (count != '0) && (count != FULL) && !fl |=> $stable(count));
  p_irq_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> full_flag);
  p_ie_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ie |=> !rx_irq);
endmodule

bind rx_trig_fifo rx_trig_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_ie(rx_ie),
  .ctl_we(ctl_we), .flush_bit(ctl_wdata[1]), .push_valid(push_valid),
  .pop(pop), .count(count), .full_flag(full_flag), .rx_irq(rx_irq)
);

// File: tb/tb_rx_trig_fifo.sv
module tb_rx_trig_fifo;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_en = 1'b1, rx_ie = 1'b0, ctl_we = 1'b0, push_valid = 1'b0, pop = 1'b0;
  logic [7:0] ctl_wdata = '0, push_data = '0, pop_data;
  logic [4:0] count;
  logic full_flag, flag_set, flag_clr, rx_irq;
  logic s_set, s_clr;
  logic [7:0] s_data;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_trig_fifo dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_ie(rx_ie),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .push_valid(push_valid),
    .push_data(push_data), .pop(pop), .pop_data(pop_data), .count(count),
    .full_flag(full_flag), .flag_set(flag_set), .flag_clr(flag_clr), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic pv, input logic [7:0] pd, input logic pp,
                     input logic we, input logic [7:0] wd);
    push_valid = pv; push_data = pd; pop = pp; ctl_we = we; ctl_wdata = wd;
    #5;
    s_set = flag_set; s_clr = flag_clr; s_data = pop_data;
    @(posedge clk); #1;
    push_valid = 0; pop = 0; ctl_we = 0;
  endtask

  task automatic t_reset;
    chk("R1 count", count, 0);
    chk("R1 flag", full_flag, 0);
    chk("R1 irq", rx_irq, 0);
    chk("R1 data", pop_data, 8'h00);
    cyc(1, 8'h33, 0, 0, 0);
    chk("R1 level1 sets flag", full_flag, 1);
    cyc(0, 0, 1, 0, 0);
  endtask

  task automatic t_order;
    for (int i = 0; i < 5; i++) cyc(1, 8'hA0 + 8'(i), 0, 0, 0);
    chk("R2 count", count, 5);
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 1, 0, 0);
      chk("R2 order", s_data, 8'hA0 + 8'(i));
    end
    for (int i = 0; i < 20; i++) begin
      cyc(1, 8'(i) ^ 8'h5A, 0, 0, 0);
      chk("R2 wrap data", pop_data, 8'(i) ^ 8'h5A);
      cyc(0, 0, 1, 0, 0);
    end
    chk("R2 empty after wrap", count, 0);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 16; i++) cyc(1, 8'h10 + 8'(i), 0, 0, 0);
    cyc(1, 8'hFF, 0, 0, 0);
    chk("R3 no set on drop", s_set, 0);
    chk("R3 count held", count, 16);
    for (int i = 0; i < 16; i++) begin
      cyc(0, 0, 1, 0, 0);
      chk("R3 contents", s_data, 8'h10 + 8'(i));
    end
    chk("R3 drained", count, 0);
  endtask

  task automatic t_rxen;
    rx_en = 0;
    cyc(1, 8'h77, 0, 0, 0);
    chk("R4 ignored", count, 0);
    chk("R4 data", pop_data, 8'h00);
    rx_en = 1;
  endtask

  task automatic t_empty_pop;
    cyc(0, 0, 1, 0, 0);
    chk("R5 data zero", s_data, 8'h00);
    chk("R5 no clr", s_clr, 0);
    chk("R5 count", count, 0);
    cyc(1, 8'h42, 0, 0, 0);
    chk("R5 state intact", pop_data, 8'h42);
    cyc(0, 0, 1, 0, 0);
  endtask

  task automatic t_trig;
    int lv [4] = '{1, 4, 8, 14};
    for (int s = 0; s < 4; s++) begin
      cyc(0, 0, 0, 1, 8'(s << 6));
      for (int k = 0; k < lv[s] - 1; k++) cyc(1, 8'(k), 0, 0, 0);
      chk("R6 below level", full_flag, 0);
      cyc(1, 8'hC0, 0, 0, 0);
      chk("R11 set pulse", s_set, 1);
      chk("R6 at level", full_flag, 1);
      cyc(1, 8'hC1, 0, 0, 0);
      cyc(0, 0, 1, 0, 0);
      chk("R7 no clr pulse", s_clr, 0);
      chk("R7 stays at level", full_flag, 1);
      cyc(0, 0, 1, 0, 0);
      chk("R11 clr pulse", s_clr, 1);
      chk("R7 cleared below", full_flag, 0);
      cyc(0, 0, 0, 1, 8'h02);
      chk("R8 flush count", count, 0);
    end
  endtask

  task automatic t_flush;
    rx_ie = 1;
    for (int i = 0; i < 3; i++) cyc(1, 8'h60 + 8'(i), 0, 0, 0);
    chk("R10 irq raised", rx_irq, 1);
    cyc(1, 8'hEE, 0, 1, 8'h02);
    chk("R11 clr on flush", s_clr, 1);
    chk("R8 count", count, 0);
    chk("R8 flag", full_flag, 0);
    chk("R8 irq", rx_irq, 0);
    chk("R8 push lost", pop_data, 8'h00);
    rx_ie = 0;
  endtask

  task automatic t_simul;
    cyc(1, 8'hB1, 0, 0, 0);
    cyc(1, 8'hB2, 0, 0, 0);
    cyc(1, 8'hB3, 1, 0, 0);
    chk("R9 popped", s_data, 8'hB1);
    chk("R9 count", count, 2);
    cyc(0, 0, 1, 0, 0);
    chk("R9 next", s_data, 8'hB2);
    cyc(0, 0, 1, 0, 0);
    chk("R9 last", s_data, 8'hB3);
    chk("R9 empty", count, 0);
  endtask

  task automatic t_irq;
    rx_ie = 1;
    cyc(0, 0, 0, 1, 8'h40);
    for (int i = 0; i < 3; i++) cyc(1, 8'(i), 0, 0, 0);
    chk("R10 no irq below", rx_irq, 0);
    cyc(1, 8'h03, 0, 0, 0);
    chk("R10 irq at level", rx_irq, 1);
    rx_ie = 0;
    cyc(0, 0, 0, 0, 0);
    chk("R10 irq gated", rx_irq, 0);
    rx_ie = 1;
    cyc(0, 0, 0, 0, 0);
    chk("R10 no spontaneous irq", rx_irq, 0);
    cyc(1, 8'h04, 0, 0, 0);
    chk("R10 irq again", rx_irq, 1);
    cyc(0, 0, 1, 0, 0);
    chk("R10 irq held", rx_irq, 1);
    cyc(0, 0, 1, 0, 0);
    chk("R10 irq cleared", rx_irq, 0);
    cyc(0, 0, 0, 1, 8'h02);
    rx_ie = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_order();
    t_overflow();
    t_rxen();
    t_empty_pop();
    t_trig();
    t_flush();
    t_simul();
    t_irq();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule